// File: doc/BRIEF.md
# Two-Bank Flow Cache with Progressive Promotion

This block caches destination addresses together with their next-hop values so that most forwarding lookups finish on chip. Storage is split into two set-associative banks. For each address, the surrounding logic computes one set index per bank and presents both with the address. A lookup probes the two candidate sets in parallel and reports a hit and the stored next hop. On a hit, the matching line moves up one place in its set's recency order.

When a lookup misses, the surrounding logic fetches the next hop from a larger table and writes it back with a fill request. The fill picks the bank whose candidate set holds more lines that have never been reused. It writes the line into the least-recent slot of that set, or into the first empty slot if the set still has one. New entries therefore start at the bottom and must earn their way up through repeated hits. Popular flows rise and stay, and one-off flows leave quickly.

The lookup request uses valid/ready. `lk_ready` is always high, so a lookup can be issued every cycle. Responses have no back-pressure: the consumer must take `rsp_valid` in the cycle it appears. The fill request also uses valid/ready. The block holds `fl_ready` low while a lookup is presented or still in flight, and the requester must keep the fill stable until it is accepted.

Top module: `fc_flow_cache`

## Requirements
- R1: After reset every line is invalid. Any lookup misses, `rsp_valid` is low until a lookup is issued, and `fl_ready` is high while no lookup is presented or in flight.
- R2: A lookup accepted in cycle c (`lk_valid` high; `lk_ready` is always high) produces `rsp_valid` for exactly one cycle, in cycle c+2. This holds for both hits and misses.
- R3: A lookup hits when a valid line in bank 0 set `lk_idx0`, or in bank 1 set `lk_idx1`, holds `lk_addr`. On a hit, `rsp_hit` is 1 and `rsp_hop` is that line's next hop, with bank 0 taking priority if both banks match. On a miss, `rsp_hit` is 0 and `rsp_hop` is 0.
- R4: A fill is accepted only in a cycle where `fl_valid` and `fl_ready` are both high. `fl_ready` is low whenever `lk_valid` is high, and also in the cycle after a lookup is accepted.
- R5: At fill time, the block counts the unpopular lines in bank 0 set `fl_idx0` and in bank 1 set `fl_idx1`. A line is unpopular if its reuse flag is clear, and invalid lines count as unpopular. The bank with the strictly larger count receives the line.
- R6: When the two counts are equal, the line goes to bank 0.
- R7: Each line has a reuse flag. A fill clears it, and the first hit on the line sets it. A filled line therefore counts as unpopular until it is hit.
- R8: Each set keeps its lines in a recency order, with position 0 at the top. Valid lines always occupy the top positions. A fill into a set that has an invalid line writes the topmost invalid position, which is the slot just below the last valid line. No valid line is evicted in that case.
- R9: A fill into a full set evicts the line at the bottom position (WAYS-1), and the new line takes that bottom position.
- R10: A hit on the line at position p>0 swaps it with the line at position p-1. A hit on the line at position 0 leaves the order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready (always 1) |
| lk_addr | input | ADDR_W | Destination address to look up |
| lk_idx0 | input | IDX_W | Candidate set in bank 0 |
| lk_idx1 | input | IDX_W | Candidate set in bank 1 |
| rsp_valid | output | 1 | Lookup response valid, one cycle |
| rsp_hit | output | 1 | Lookup found the address |
| rsp_hop | output | HOP_W | Next hop on hit, zero on miss |
| fl_valid | input | 1 | Fill request valid |
| fl_ready | output | 1 | Fill request ready |
| fl_addr | input | ADDR_W | Address of the new line |
| fl_hop | input | HOP_W | Next hop of the new line |
| fl_idx0 | input | IDX_W | Candidate set in bank 0 for the fill |
| fl_idx1 | input | IDX_W | Candidate set in bank 1 for the fill |

## Verification
The bench locates each filled line by probing it with one index that points at an unused set. This shows which bank took the line.

- **Bank choice.** Equal counts must send the line to bank 0, and a bank whose set holds a reused line must lose. A set holding a filled but never-hit line must still count that line as unpopular. A design that counted only empty slots would send that line to the wrong bank, and the probe would show a miss.
- **Insertion and eviction.** The bench fills a set beyond its capacity twice in a row. The second newcomer must evict the first, which proves new lines land at the bottom. A design that inserted at the top would evict an older line instead.
- **Promotion and fill gating.** A single hit must lift a line above the bottom so that the next fill evicts its neighbour instead. The bench also presents a fill together with a lookup and checks that the fill waits until the lookup has left the pipeline.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {
    BANK_L = 1'b0,
    BANK_R = 1'b1
  } bank_e;
  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/fc_pick.sv
module fc_pick
  import fc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] cnt_l,
  input  logic [CNT_W-1:0] cnt_r,
  output bank_e            sel
);
  // strictly larger right count wins; a tie stays on the left bank
  always_comb sel = (cnt_r > cnt_l) ? BANK_R : BANK_L;
endmodule

// File: rtl/fc_bank.sv
module fc_bank #(
  parameter int ADDR_W = 32,
  parameter int HOP_W  = 8,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [HOP_W-1:0]  lk_hop,
  input  logic              fl_en,
  input  logic [IDX_W-1:0]  fl_idx,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [HOP_W-1:0]  fl_hop,
  output logic [CNT_W-1:0]  fl_unpop
);
  logic [ADDR_W-1:0] tag_q [SETS][WAYS];
  logic [HOP_W-1:0]  hop_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   reu_q [SETS];
  logic [WAY_W-1:0]  ord_q [SETS][WAYS];   // position -> way, position 0 on top

  logic [WAY_W-1:0] hit_pos, hit_way, up_way;
  logic [WAY_W-1:0] vic_pos, vic_way;
  logic             vic_found;

  // probe the set in position order; first matching position wins
  always_comb begin
    lk_hit  = 1'b0;
    hit_pos = '0;
    for (int p = 0; p < WAYS; p++) begin
      if (!lk_hit && vld_q[lk_idx][ord_q[lk_idx][p]] &&
          tag_q[lk_idx][ord_q[lk_idx][p]] == lk_addr) begin
        lk_hit  = 1'b1;
        hit_pos = WAY_W'(p);
      end
    end
    hit_way = ord_q[lk_idx][hit_pos];
    up_way  = ord_q[lk_idx][hit_pos - WAY_W'(1)];
    lk_hop  = lk_hit ? hop_q[lk_idx][hit_way] : '0;
  end

  // unpopular lines and the slot a fill writes
  always_comb begin
    fl_unpop  = '0;
    vic_found = 1'b0;
    vic_pos   = WAY_W'(WAYS - 1);
    for (int w = 0; w < WAYS; w++)
      fl_unpop = fl_unpop + CNT_W'(!reu_q[fl_idx][w]);
    for (int p = 0; p < WAYS; p++) begin
      if (!vic_found && !vld_q[fl_idx][ord_q[fl_idx][p]]) begin
        vic_found = 1'b1;
        vic_pos   = WAY_W'(p);
      end
    end
    vic_way = ord_q[fl_idx][vic_pos];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        reu_q[s] <= '0;
        for (int p = 0; p < WAYS; p++) begin
          ord_q[s][p] <= WAY_W'(p);
          tag_q[s][p] <= '0;
          hop_q[s][p] <= '0;
        end
      end
    end else begin
      if (lk_en && lk_hit) begin
        reu_q[lk_idx][hit_way] <= 1'b1;
        if (hit_pos != '0) begin
          ord_q[lk_idx][hit_pos]              <= up_way;
          ord_q[lk_idx][hit_pos - WAY_W'(1)]  <= hit_way;
        end
      end
      if (fl_en) begin
        tag_q[fl_idx][vic_way] <= fl_addr;
        hop_q[fl_idx][vic_way] <= fl_hop;
        vld_q[fl_idx][vic_way] <= 1'b1;
        reu_q[fl_idx][vic_way] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fc_flow_cache.sv
module fc_flow_cache
  import fc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HOP_W  = 8,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [IDX_W-1:0]  lk_idx0,
  input  logic [IDX_W-1:0]  lk_idx1,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [HOP_W-1:0]  rsp_hop,
  input  logic              fl_valid,
  output logic              fl_ready,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [HOP_W-1:0]  fl_hop,
  input  logic [IDX_W-1:0]  fl_idx0,
  input  logic [IDX_W-1:0]  fl_idx1
);
  logic              s1_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [IDX_W-1:0]  s1_idx [NUM_BANKS];

  logic              b_hit   [NUM_BANKS];
  logic [HOP_W-1:0]  b_hop   [NUM_BANKS];
  logic [CNT_W-1:0]  b_unpop [NUM_BANKS];
  logic [IDX_W-1:0]  b_flidx [NUM_BANKS];
  logic              fl_acc;
  bank_e             fl_sel;

  assign lk_ready = 1'b1;
  assign fl_ready = !s1_v && !lk_valid;
  assign fl_acc   = fl_valid && fl_ready;
  assign b_flidx[0] = fl_idx0;
  assign b_flidx[1] = fl_idx1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_addr   <= '0;
      s1_idx[0] <= '0;
      s1_idx[1] <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_hop   <= '0;
    end else begin
      s1_v      <= lk_valid;
      s1_addr   <= lk_addr;
      s1_idx[0] <= lk_idx0;
      s1_idx[1] <= lk_idx1;
      rsp_valid <= s1_v;
      rsp_hit   <= s1_v && (b_hit[0] || b_hit[1]);
      rsp_hop   <= !s1_v ? '0 : (b_hit[0] ? b_hop[0] : b_hop[1]);
    end
  end

  fc_pick #(.CNT_W(CNT_W)) i_pick (
    .cnt_l (b_unpop[0]),
    .cnt_r (b_unpop[1]),
    .sel   (fl_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fc_bank #(
      .ADDR_W (ADDR_W),
      .HOP_W  (HOP_W),
      .SETS   (SETS),
      .WAYS   (WAYS)
    ) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (s1_v),
      .lk_idx   (s1_idx[b]),
      .lk_addr  (s1_addr),
      .lk_hit   (b_hit[b]),
      .lk_hop   (b_hop[b]),
      .fl_en    (fl_acc && (fl_sel == bank_e'(b))),
      .fl_idx   (b_flidx[b]),
      .fl_addr  (fl_addr),
      .fl_hop   (fl_hop),
      .fl_unpop (b_unpop[b])
    );
  end
endmodule

// File: rtl/fc_flow_cache_chk.sv
module fc_flow_cache_chk #(
  parameter int HOP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [HOP_W-1:0] rsp_hop,
  input logic             fl_valid,
  input logic             fl_ready
);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |-> ##2 rsp_valid);

  a_r2_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid && lk_ready, 2));

  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_hop == '0));

  a_r4_fill_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_ready) |=> !rsp_valid);

  a_r4_inflight_block: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> !fl_ready);
endmodule

bind fc_flow_cache fc_flow_cache_chk #(.HOP_W(HOP_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_hop   (rsp_hop),
  .fl_valid  (fl_valid),
  .fl_ready  (fl_ready)
);

// File: tb/test_fc_flow_cache.sv
module test_fc_flow_cache;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int HOP_W  = 8;
  localparam int SETS   = 16;
  localparam int WAYS   = 4;
  localparam int IDX_W  = $clog2(SETS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_ready;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic [IDX_W-1:0] lk_idx0 = '0, lk_idx1 = '0;
  logic rsp_valid, rsp_hit;
  logic [HOP_W-1:0] rsp_hop;
  logic fl_valid = 1'b0, fl_ready;
  logic [ADDR_W-1:0] fl_addr = '0;
  logic [HOP_W-1:0] fl_hop = '0;
  logic [IDX_W-1:0] fl_idx0 = '0, fl_idx1 = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_flow_cache #(.ADDR_W(ADDR_W), .HOP_W(HOP_W), .SETS(SETS), .WAYS(WAYS)) i_fc_flow_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_idx0(lk_idx0), .lk_idx1(lk_idx1),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hop(rsp_hop),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_addr(fl_addr), .fl_hop(fl_hop),
    .fl_idx0(fl_idx0), .fl_idx1(fl_idx1)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lookup with R2 timing check, then R3 result check
  task automatic lookup(string req, logic [31:0] addr, int i0, int i1, bit exp_hit,
                        logic [7:0] exp_hop);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = addr;
    lk_idx0 = IDX_W'(i0); lk_idx1 = IDX_W'(i1);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R2", "rsp_valid early", 32'(rsp_valid), 0);
    @(negedge clk);
    check("R2", "rsp_valid at c+2", 32'(rsp_valid), 1);
    check(req, "rsp_hit", 32'(rsp_hit), 32'(exp_hit));
    check(req, "rsp_hop", 32'(rsp_hop), 32'(exp_hop));
  endtask

  task automatic fill(logic [31:0] addr, logic [7:0] hop, int i0, int i1);
    @(negedge clk);
    fl_valid = 1'b1; fl_addr = addr; fl_hop = hop;
    fl_idx0 = IDX_W'(i0); fl_idx1 = IDX_W'(i1);
    while (!fl_ready) @(negedge clk);
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    check("R1", "fl_ready idle", 32'(fl_ready), 1);
    lookup("R1", 32'h0A00_0001, 1, 1, 1'b0, 8'h00);
  endtask

  task automatic t_tie;
    fill(32'h0A00_0001, 8'h11, 1, 1);                 // 4 vs 4 -> bank 0
    lookup("R6", 32'h0A00_0001, 1, 7, 1'b1, 8'h11);
    lookup("R6", 32'h0A00_0001, 7, 1, 1'b0, 8'h00);
  endtask

  task automatic t_larger;
    fill(32'h0B00_0002, 8'h22, 2, 2);                 // tie -> bank 0 set 2
    lookup("R3", 32'h0B00_0002, 2, 6, 1'b1, 8'h22);   // now reused: 3 unpopular
    fill(32'h0B00_0003, 8'h23, 2, 2);                 // 3 vs 4 -> bank 1
    lookup("R5", 32'h0B00_0003, 6, 2, 1'b1, 8'h23);
    lookup("R5", 32'h0B00_0003, 2, 6, 1'b0, 8'h00);
  endtask

  task automatic t_unreused_counts;
    fill(32'h0C00_0004, 8'h34, 3, 3);                 // bank 0 set 3
    fill(32'h0C00_0005, 8'h35, 3, 3);                 // unreused still counts: 4 vs 4 -> bank 0
    lookup("R7", 32'h0C00_0005, 3, 7, 1'b1, 8'h35);
    lookup("R7", 32'h0C00_0005, 7, 3, 1'b0, 8'h00);
  endtask

  task automatic t_evict_bottom;
    for (int k = 0; k < 6; k++)
      fill(32'h0D00_0000 + 32'(k), 8'h40 + 8'(k), 4, 7);
    lookup("R9", 32'h0D00_0003, 4, 7, 1'b0, 8'h00);   // evicted by 4th newcomer
    lookup("R9", 32'h0D00_0004, 4, 7, 1'b0, 8'h00);   // newcomer sat at bottom
    lookup("R9", 32'h0D00_0005, 4, 7, 1'b1, 8'h45);
    lookup("R8", 32'h0D00_0000, 4, 7, 1'b1, 8'h40);
    lookup("R8", 32'h0D00_0001, 4, 7, 1'b1, 8'h41);
    lookup("R8", 32'h0D00_0002, 4, 7, 1'b1, 8'h42);
  endtask

  task automatic t_promote;
    for (int k = 0; k < 4; k++)
      fill(32'h0E00_0000 + 32'(k), 8'h50 + 8'(k), 5, 6);   // tie -> bank 0 set 5
    fill(32'h0F00_0001, 8'h61, 2, 6);                 // 3 vs 4 -> bank 1 set 6
    lookup("R3", 32'h0F00_0001, 7, 6, 1'b1, 8'h61);   // bank 1 set 6 now 3
    lookup("R10", 32'h0E00_0003, 5, 0, 1'b1, 8'h53);  // rises above line 2
    fill(32'h0E00_0004, 8'h54, 5, 6);                 // 3 vs 3 -> bank 0, evicts bottom
    lookup("R10", 32'h0E00_0002, 5, 0, 1'b0, 8'h00);
    lookup("R10", 32'h0E00_0003, 5, 0, 1'b1, 8'h53);
    lookup("R9", 32'h0E00_0004, 5, 0, 1'b1, 8'h54);
    lookup("R10", 32'h0E00_0000, 5, 0, 1'b1, 8'h50);
  endtask

  task automatic t_fill_gate;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h0A00_0001; lk_idx0 = 1; lk_idx1 = 7;
    fl_valid = 1'b1; fl_addr = 32'h0700_0007; fl_hop = 8'h77; fl_idx0 = 7; fl_idx1 = 5;
    #1 check("R4", "fl_ready with lookup presented", 32'(fl_ready), 0);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R4", "fl_ready with lookup in flight", 32'(fl_ready), 0);
    @(negedge clk);
    check("R4", "fl_ready after lookup", 32'(fl_ready), 1);
    check("R3", "gated lookup hit", 32'(rsp_hit), 1);
    check("R3", "gated lookup hop", 32'(rsp_hop), 32'h11);
    @(negedge clk);
    fl_valid = 1'b0;
    lookup("R4", 32'h0700_0007, 7, 5, 1'b1, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_tie;
    t_larger;
    t_unreused_counts;
    t_evict_bottom;
    t_promote;
    t_fill_gate;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule